// File: doc/BRIEF.md
# Time-Slot List TDM Sequencer

This block divides a serial audio super frame into one-byte time slots and decides, slot by slot, where each byte goes. A programmable slot list holds one entry per slot. The entry chooses one of the serial data lines and one action for the slot. The action can capture the byte received on that line into the input buffer, send a byte from the output buffer onto the line, loop the byte received on the line straight back out, or resend a byte that was captured earlier in another slot. Devices that share one data line each take their own slots.

The block runs on the system clock. It receives a `bitTick` strobe for every serial bit clock and a `wsEdge` strobe that marks the frame start. The bit-level shift registers sit outside the block. They hand over one deserialized byte per line (`rxData`) and accept one byte to transmit (`txData` on `txLine`) at each slot end. Software writes the list through a single write port into a shadow copy. The sequencer loads the shadow copy into its working copy only when a super frame starts, so a frame is never run with a half-written list.

Top module: `tdm_slot_sequencer`

## Requirements
- R1: While `rstN` is low, every output is 0. The shadow list, the working list and the per-slot byte store are also cleared to 0.
- R2: No slot events occur when `enable` is low, or when `enable` is high but no word-select edge has been seen yet. The slot pointer starts at slot 0 on the first `bitTick` with `wsEdge` high after `enable` rises. That tick counts as bit 0 of slot 0. Later `wsEdge` pulses are ignored until `enable` drops.
- R3: A slot ends on every eighth `bitTick`. Its event appears on the outputs one clock after that tick. `evtSlot` gives the index of the slot, and the pointer then moves to the next slot.
- R4: List entry encoding: bits [2:0] select the data line, bits [4:3] select the action (0 none, 1 capture, 2 transmit, 3 loop), bit 5 selects the copy source, bits [10:6] give the source slot, and bit 11 marks the end of the frame. A capture entry pulses `inCapValid` with `inCapData` set to the received byte of the selected line. Line values 5 to 7 read as 0x00.
- R5: A transmit entry with bit 5 clear drives `outBufPop` high in the clock of the slot-end tick. One clock later it pulses `txValid` with `txData` equal to `outBufData` from that clock and `txLine` equal to the selected line.
- R6: A loop entry pulses `txValid` with `txData` equal to the received byte of the selected line in the same slot. It raises neither `inCapValid` nor `outBufPop`.
- R7: A transmit entry with bit 5 set sends the byte last stored by the source slot. Capture and loop slots store bytes. If the source slot has not yet run in the current super frame, the byte comes from the previous super frame. The value is 0x00 if the source slot has not stored a byte since reset.
- R8: After the slot whose entry has bit 11 set, the pointer returns to slot 0. It also returns to slot 0 after slot 31.
- R9: List writes go to the shadow copy at any time. The working copy loads the shadow copy only at the frame-start sync and at each wrap to slot 0. A write made while a frame is running therefore takes effect from the next super frame.
- R10: An entry with action 0 produces no `inCapValid`, `txValid` or `outBufPop` for its slot. The slot still uses its eight bit ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the sequencer; low returns it to the unsynced state |
| bitTick | input | 1 | One-clock strobe per serial bit clock |
| wsEdge | input | 1 | Word-select edge marker, qualified by bitTick |
| cfgWe | input | 1 | Slot-list write strobe |
| cfgAddr | input | 5 | Slot-list entry index |
| cfgData | input | 12 | Slot-list entry value |
| rxData | input | 40 | Received byte per line, line n at bits [8n+7:8n] |
| outBufData | input | 8 | Byte at the head of the output buffer |
| outBufPop | output | 1 | Takes the head byte of the output buffer |
| inCapValid | output | 1 | Captured byte for the input buffer is valid |
| inCapData | output | 8 | Captured byte |
| txValid | output | 1 | Byte to transmit is valid |
| txLine | output | 3 | Data line for the transmit byte |
| txData | output | 8 | Byte to transmit |
| evtSlot | output | 5 | Slot index of the latest event |

## Verification
The list sends capture, buffer-transmit, loop and slot-copy actions across all five lines and one invalid line. Random received bytes in every slot show whether the right line, the right slot and the right source were picked. The copy entries cover both orders. One copy reads a slot already captured in the same frame. The other reads a slot that has not yet run, which tells current-frame data apart from last-frame data. Bit ticks arrive both on every clock and with gaps, and ticks before the sync and extra word-select pulses are mixed in, so a pointer that counts clocks instead of ticks or resyncs later shows up as a wrong `evtSlot`. A list rewrite in the middle of a frame, and removing the end mark to get a full 32-slot frame, test when list changes take effect and both ways the pointer wraps.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int SLOT_W  = 5;
  localparam int LINE_W  = 3;
  localparam int ENTRY_W = 1 + SLOT_W + 1 + 2 + LINE_W;

  typedef enum logic [1:0] {
    DIR_NONE = 2'd0,
    DIR_IN   = 2'd1,
    DIR_OUT  = 2'd2,
    DIR_LOOP = 2'd3
  } dir_e;

  // one slot-list entry, bit 11 down to bit 0
  typedef struct packed {
    logic              last;
    logic [SLOT_W-1:0] src;
    logic              copy;
    dir_e              dir;
    logic [LINE_W-1:0] line;
  } entry_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              fire;
    dir_e              dir;
    logic [LINE_W-1:0] line;
    logic              copy;
    logic [SLOT_W-1:0] src;
    logic [SLOT_W-1:0] slot;
  } strobe_t;
endpackage

// File: rtl/tdm_slot_ctrl.sv
module tdm_slot_ctrl
  import tdm_pkg::*;
#(
  parameter int NUM_SLOTS     = 32,
  parameter int BITS_PER_SLOT = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               bitTick,
  input  logic               wsEdge,
  input  logic               cfgWe,
  input  logic [SLOT_W-1:0]  cfgAddr,
  input  logic [ENTRY_W-1:0] cfgData,
  output strobe_t            stb
);
  localparam int CNT_W = $clog2(BITS_PER_SLOT);
  localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(BITS_PER_SLOT - 1);
  localparam logic [SLOT_W-1:0] TOP_SLOT = SLOT_W'(NUM_SLOTS - 1);

  entry_t            shadowList [NUM_SLOTS];
  entry_t            activeList [NUM_SLOTS];
  entry_t            cur;
  logic              synced;
  logic [CNT_W-1:0]  bitCnt;
  logic [SLOT_W-1:0] slotPtr;
  logic              slotEnd, wrap, syncNow, loadList;

  assign cur      = activeList[slotPtr];
  assign syncNow  = enable && !synced && bitTick && wsEdge;
  assign slotEnd  = enable && synced && bitTick && (bitCnt == LAST_BIT);
  assign wrap     = cur.last || (slotPtr == TOP_SLOT);
  assign loadList = syncNow || (slotEnd && wrap);

  // software writes land in the shadow copy only
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SLOTS; i++) shadowList[i] <= '0;
    end else if (cfgWe && cfgAddr <= TOP_SLOT) begin
      shadowList[cfgAddr] <= entry_t'(cfgData);
    end
  end

  // working copy refreshed at super-frame boundaries
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SLOTS; i++) activeList[i] <= '0;
    end else if (loadList) begin
      activeList <= shadowList;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      synced  <= 1'b0;
      bitCnt  <= '0;
      slotPtr <= '0;
    end else if (!enable) begin
      synced  <= 1'b0;
      bitCnt  <= '0;
      slotPtr <= '0;
    end else if (!synced) begin
      if (syncNow) begin
        synced  <= 1'b1;
        bitCnt  <= CNT_W'(1);
        slotPtr <= '0;
      end
    end else if (bitTick) begin
      if (bitCnt == LAST_BIT) begin
        bitCnt  <= '0;
        slotPtr <= wrap ? '0 : slotPtr + 1'b1;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  always_comb begin
    stb.fire = slotEnd;
    stb.dir  = cur.dir;
    stb.line = cur.line;
    stb.copy = cur.copy;
    stb.src  = cur.src;
    stb.slot = slotPtr;
  end
endmodule

// File: rtl/tdm_slot_dp.sv
module tdm_slot_dp
  import tdm_pkg::*;
#(
  parameter int NUM_LINES = 5,
  parameter int NUM_SLOTS = 32,
  parameter int BYTE_W    = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobe_t                     stb,
  input  logic [NUM_LINES*BYTE_W-1:0] rxData,
  input  logic [BYTE_W-1:0]           outBufData,
  output logic                        outBufPop,
  output logic                        inCapValid,
  output logic [BYTE_W-1:0]           inCapData,
  output logic                        txValid,
  output logic [LINE_W-1:0]           txLine,
  output logic [BYTE_W-1:0]           txData,
  output logic [SLOT_W-1:0]           evtSlot
);
  logic [BYTE_W-1:0] slotMem [NUM_SLOTS];
  logic [BYTE_W-1:0] rxByte;
  logic              doIn, doTx, doStore;

  always_comb begin
    rxByte = '0;
    for (int l = 0; l < NUM_LINES; l++)
      if (stb.line == LINE_W'(l)) rxByte = rxData[l*BYTE_W +: BYTE_W];
  end

  assign doIn      = stb.fire && (stb.dir == DIR_IN);
  assign doTx      = stb.fire && (stb.dir == DIR_OUT || stb.dir == DIR_LOOP);
  assign doStore   = stb.fire && (stb.dir == DIR_IN || stb.dir == DIR_LOOP);
  assign outBufPop = stb.fire && (stb.dir == DIR_OUT) && !stb.copy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SLOTS; i++) slotMem[i] <= '0;
    end else if (doStore) begin
      slotMem[stb.slot] <= rxByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inCapValid <= 1'b0;
      inCapData  <= '0;
      txValid    <= 1'b0;
      txLine     <= '0;
      txData     <= '0;
      evtSlot    <= '0;
    end else begin
      inCapValid <= doIn;
      txValid    <= doTx;
      if (stb.fire) evtSlot <= stb.slot;
      if (doIn) inCapData <= rxByte;
      if (doTx) begin
        txLine <= stb.line;
        if (stb.dir == DIR_LOOP) txData <= rxByte;
        else if (stb.copy)       txData <= slotMem[stb.src];
        else                     txData <= outBufData;
      end
    end
  end
endmodule

// File: rtl/tdm_slot_sequencer.sv
module tdm_slot_sequencer
  import tdm_pkg::*;
#(
  parameter int NUM_LINES     = 5,
  parameter int NUM_SLOTS     = 32,
  parameter int BYTE_W        = 8,
  parameter int BITS_PER_SLOT = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        enable,
  input  logic                        bitTick,
  input  logic                        wsEdge,
  input  logic                        cfgWe,
  input  logic [4:0]                  cfgAddr,
  input  logic [11:0]                 cfgData,
  input  logic [NUM_LINES*BYTE_W-1:0] rxData,
  input  logic [BYTE_W-1:0]           outBufData,
  output logic                        outBufPop,
  output logic                        inCapValid,
  output logic [BYTE_W-1:0]           inCapData,
  output logic                        txValid,
  output logic [2:0]                  txLine,
  output logic [BYTE_W-1:0]           txData,
  output logic [4:0]                  evtSlot
);
  strobe_t stb;

  tdm_slot_ctrl #(.NUM_SLOTS(NUM_SLOTS), .BITS_PER_SLOT(BITS_PER_SLOT)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .bitTick(bitTick), .wsEdge(wsEdge),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData), .stb(stb)
  );

  tdm_slot_dp #(.NUM_LINES(NUM_LINES), .NUM_SLOTS(NUM_SLOTS), .BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rxData(rxData), .outBufData(outBufData),
    .outBufPop(outBufPop), .inCapValid(inCapValid), .inCapData(inCapData),
    .txValid(txValid), .txLine(txLine), .txData(txData), .evtSlot(evtSlot)
  );
endmodule

// File: rtl/tdm_slot_sequencer_chk.sv
module tdm_slot_sequencer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       enable,
  input logic [7:0] outBufData,
  input logic       outBufPop,
  input logic       inCapValid,
  input logic       txValid,
  input logic [7:0] txData
);
  // R4
  cap_excludes_tx_chk: assert property (@(posedge clk) disable iff (!rstN)
    inCapValid |-> !txValid);

  // R5
  pop_then_tx_chk: assert property (@(posedge clk) disable iff (!rstN)
    outBufPop |=> (txValid && txData == $past(outBufData)));

  // R5
  pop_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    outBufPop |-> enable);

  // R2
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!inCapValid && !txValid));

  // R3
  event_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inCapValid || txValid) |=> !(inCapValid || txValid));
endmodule

bind tdm_slot_sequencer tdm_slot_sequencer_chk u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .outBufData(outBufData),
  .outBufPop(outBufPop), .inCapValid(inCapValid), .txValid(txValid), .txData(txData)
);

// File: tb/test_tdm_slot_sequencer.sv
`timescale 1ns/1ps
module test_tdm_slot_sequencer;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN = 1'b0, enable = 1'b0, bitTick = 1'b0, wsEdge = 1'b0, cfgWe = 1'b0;
  logic [4:0]  cfgAddr = '0;
  logic [11:0] cfgData = '0;
  logic [39:0] rxData = '0;
  logic [7:0]  outBufData = '0;
  logic        outBufPop, inCapValid, txValid;
  logic [7:0]  inCapData, txData;
  logic [2:0]  txLine;
  logic [4:0]  evtSlot;

  tdm_slot_sequencer i_tdm_slot_sequencer (
    .clk(clk), .rstN(rstN), .enable(enable), .bitTick(bitTick), .wsEdge(wsEdge),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData), .rxData(rxData),
    .outBufData(outBufData), .outBufPop(outBufPop), .inCapValid(inCapValid),
    .inCapData(inCapData), .txValid(txValid), .txLine(txLine), .txData(txData),
    .evtSlot(evtSlot)
  );

  int    tests = 0, fails = 0;
  bit    done = 0;
  string phase = "R1";

  // ---------------- behavioural reference ----------------
  logic [11:0] mShadow [32];
  logic [11:0] mActive [32];
  logic [7:0]  mMem [32];
  bit          mSynced = 0;
  int          mBit = 0, mSlot = 0;
  bit          eIn = 0, eTx = 0;
  logic [7:0]  eInD = 0, eTxD = 0;
  logic [2:0]  eLine = 0;
  logic [4:0]  eSlot = 0;
  string       eTag = "R1";

  initial for (int i = 0; i < 32; i++) begin mShadow[i] = 0; mActive[i] = 0; mMem[i] = 0; end

  function automatic logic [7:0] pickLine(input int l);
    if (l < 5) return rxData[l*8 +: 8];
    return 8'h00;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 32; i++) begin mShadow[i] = 0; mActive[i] = 0; mMem[i] = 0; end
      mSynced = 0; mBit = 0; mSlot = 0;
      eIn = 0; eTx = 0; eInD = 0; eTxD = 0; eLine = 0; eSlot = 0; eTag = "R1";
    end else begin
      logic [11:0] e;
      bit fire, wrapNow;
      logic [7:0] rb;
      e = mActive[mSlot];
      fire = enable && mSynced && bitTick && mBit == 7;
      eIn = 0; eTx = 0; eTag = phase;
      if (fire) begin
        rb = pickLine(int'(e[2:0]));
        eSlot = 5'(mSlot);
        case (e[4:3])
          2'd1: begin eIn = 1; eInD = rb; mMem[mSlot] = rb; eTag = "R4"; end
          2'd2: begin
            eTx = 1; eLine = e[2:0];
            if (e[5]) begin eTxD = mMem[e[10:6]]; eTag = "R7"; end
            else begin eTxD = outBufData; eTag = "R5"; end
          end
          2'd3: begin eTx = 1; eLine = e[2:0]; eTxD = rb; mMem[mSlot] = rb; eTag = "R6"; end
          default: eTag = "R10";
        endcase
      end
      if (!enable) begin
        mSynced = 0; mBit = 0; mSlot = 0;
      end else if (!mSynced) begin
        if (bitTick && wsEdge) begin
          mSynced = 1; mBit = 1; mSlot = 0;
          for (int i = 0; i < 32; i++) mActive[i] = mShadow[i];
        end
      end else if (bitTick) begin
        if (mBit == 7) begin
          mBit = 0;
          wrapNow = e[11] || mSlot == 31;
          if (wrapNow) begin
            mSlot = 0; eTag = (eTag == phase) ? "R8" : eTag;
            for (int i = 0; i < 32; i++) mActive[i] = mShadow[i];
          end else mSlot = mSlot + 1;
        end else mBit = mBit + 1;
      end
      if (cfgWe) mShadow[cfgAddr] = cfgData;
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (!done) begin
      bit expPop;
      logic [11:0] e;
      #1;
      e = mActive[mSlot];
      expPop = enable && mSynced && bitTick && mBit == 7 && e[4:3] == 2'd2 && !e[5];
      tests++;
      if (outBufPop !== expPop || inCapValid !== eIn || inCapData !== eInD ||
          txValid !== eTx || txData !== eTxD || txLine !== eLine || evtSlot !== eSlot) begin
        fails++;
        $display("FAIL %s t=%0t actual pop=%0b cap=%0b/%02h tx=%0b/%0d/%02h slot=%0d expected pop=%0b cap=%0b/%02h tx=%0b/%0d/%02h slot=%0d",
                 (expPop || outBufPop) ? "R5" : eTag, $time, outBufPop, inCapValid, inCapData,
                 txValid, txLine, txData, evtSlot, expPop, eIn, eInD, eTx, eLine, eTxD, eSlot);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [11:0] mk(input int line, input int dir, input bit cp,
                                     input int src, input bit last);
    return {last, 5'(src), cp, 2'(dir), 3'(line)};
  endfunction

  task automatic randData();
    logic [63:0] r;
    r = {$urandom(), $urandom()};
    rxData = r[39:0];
    outBufData = 8'($urandom());
  endtask

  task automatic cycle(input bit tick, input bit ws);
    @(negedge clk);
    bitTick = tick; wsEdge = ws; cfgWe = 0;
    randData();
  endtask

  task automatic runTicks(input int n, input int gap);
    for (int k = 0; k < n; k++) begin
      for (int g = 1; g < gap; g++) cycle(1'b0, 1'b0);
      cycle(1'b1, 1'b0);
    end
  endtask

  task automatic writeEntry(input int a, input logic [11:0] d);
    @(negedge clk);
    bitTick = 0; wsEdge = 0;
    cfgWe = 1; cfgAddr = 5'(a); cfgData = d;
    randData();
  endtask

  task automatic finishRun();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      finishRun();
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    #1;
    tests++;
    if ({outBufPop, inCapValid, inCapData, txValid, txLine, txData, evtSlot} !== '0) begin
      fails++;
      $display("FAIL R1 actual=%0h expected=0",
               {outBufPop, inCapValid, inCapData, txValid, txLine, txData, evtSlot});
    end
    @(negedge clk); rstN = 1;

    // R9: list written while idle, loaded at sync
    phase = "R9";
    writeEntry(0, mk(0, 1, 0, 0, 0));
    writeEntry(1, mk(4, 1, 0, 0, 0));
    writeEntry(2, mk(1, 2, 0, 0, 0));
    writeEntry(3, mk(2, 3, 0, 0, 0));
    writeEntry(4, mk(3, 2, 1, 1, 0));   // R7 copy of an earlier slot
    writeEntry(5, mk(0, 2, 1, 6, 0));   // R7 copy of a later slot
    writeEntry(6, mk(3, 1, 0, 0, 0));
    writeEntry(7, mk(5, 1, 0, 0, 1));   // R4 invalid line, R8 end mark

    // R2: ticks before any word-select edge produce nothing
    phase = "R2";
    @(negedge clk); enable = 1;
    runTicks(20, 1);
    cycle(1'b1, 1'b1);

    // R3: steady run, ticks on every clock then with gaps
    phase = "R3";
    runTicks(64 * 2, 1);
    runTicks(12, 3);
    phase = "R2";
    cycle(1'b1, 1'b1);             // extra word-select edge, ignored
    phase = "R3";
    runTicks(64 * 2, 2);

    // R9: rewrite slot 2 mid-frame while running
    phase = "R9";
    runTicks(19, 1);
    writeEntry(2, mk(1, 1, 0, 0, 0));
    runTicks(64 * 2, 1);

    // R8: drop end mark, full 32-slot frame wraps after slot 31
    phase = "R8";
    writeEntry(7, mk(2, 2, 1, 3, 0));
    writeEntry(31, mk(4, 3, 0, 0, 0));
    runTicks(64 + 256 * 2 + 40, 1);

    // R2: disable stops all events
    phase = "R2";
    @(negedge clk); enable = 0;
    runTicks(40, 1);
    phase = "R10";
    enable = 1;
    cycle(1'b1, 1'b1);
    runTicks(256 + 16, 2);

    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule